// File: doc/BRIEF.md
# Page Request Header Matcher

This block holds the page requests that a host has programmed and compares each decoded page header against them. It has eight request slots in two groups of four. Each slot has seven 5-bit entries, one per header digit: magazine, page tens, page units, hour tens, hour units, minute tens and minute units. Each entry carries a do-care flag. The host writes one entry at a time, addressing it by slot and column. A group-select input picks which four slots take part in a comparison.

For every header strobe, the block reports one clock later whether a slot in the active group matched, which slot won, and whether the winner asks for its page to be captured or held. For each slot it also keeps an active-low found flag and a looking-for flag. The surrounding acquisition logic uses the capture decision to route the rows that follow; storing those rows and Hamming-decoding the header happen elsewhere.

Top module: `page_req_matcher`

## Requirements
- R1: A write with `req_we` high stores `req_data` into entry (`req_slot`, `req_col`). In column 0, bits 2:0 are the magazine, bit 3 is the hold flag and bit 4 is do-care. In columns 1 to 6, bits 3:0 are the digit and bit 4 is do-care. The columns in order are: magazine, page tens, page units, hour tens, hour units, minute tens, minute units.
- R2: An entry takes part in the comparison only when its do-care bit is 1. Only the field width of each digit is compared (magazine 3 bits, hour tens 2 bits, minute tens 3 bits, all others 4 bits); the stored bits above that width are ignored.
- R3: Only the slots numbered `grp_sel*4` to `grp_sel*4+3` are compared with a header.
- R4: When several slots in the active group match, `res_slot` reports the lowest-numbered one.
- R5: A header presented with `hdr_ham_err` high never produces a match.
- R6: `res_valid` is high in exactly the cycle after a cycle with `hdr_valid` high. When there is no match, `res_hit`, `res_capture`, `res_held` and `res_slot` are all 0.
- R7: On a match, `res_capture` is 1 if the winning slot's hold flag is 1. If the hold flag is 0, `res_held` is 1 instead.
- R8: `found_n` resets to all ones. A slot's bit goes to 0 when that slot wins a match, and returns to 1 when any entry of that slot is written.
- R9: `looking` resets to all zeros. A slot's bit is set when one of its entries is written, and cleared when that slot wins a match. If a write and a win hit the same slot in the same cycle, the write takes priority.
- R10: A write to column 7 is discarded. It changes no entry and neither status flag.
- R11: Reset clears every entry to zero. As a result, every slot matches any error-free header with its hold flag low, and the outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_we | input | 1 | Request entry write strobe |
| req_slot | input | SLOT_W | Slot to write; the top bit is the group |
| req_col | input | 3 | Column to write (0 to 6) |
| req_data | input | 5 | Entry value: do-care in bit 4 |
| grp_sel | input | GRP_W | Group of slots compared with headers |
| hdr_valid | input | 1 | Header digits are present this cycle |
| hdr_ham_err | input | 1 | Some address byte of the header had a Hamming error |
| hdr_mag | input | 3 | Received magazine |
| hdr_pg_tens | input | 4 | Received page tens |
| hdr_pg_units | input | 4 | Received page units |
| hdr_hr_tens | input | 2 | Received hour tens |
| hdr_hr_units | input | 4 | Received hour units |
| hdr_mn_tens | input | 3 | Received minute tens |
| hdr_mn_units | input | 4 | Received minute units |
| res_valid | output | 1 | Result for the previous cycle's header |
| res_hit | output | 1 | A slot matched |
| res_slot | output | SLOT_W | Winning slot |
| res_capture | output | 1 | Capture the page |
| res_held | output | 1 | Matched, but the page is held |
| found_n | output | NSLOT | Per-slot found flag, active low |
| looking | output | NSLOT | Per-slot looking-for flag |

## Verification
A corrupted stored entry shows up at the result of the very next header that exercises the affected digit. It appears as a missing hit, a wrong slot or a flipped capture/hold choice. A wrong priority or group decode shows only when two slots match together, or when a header fits a slot in the inactive group. The bench therefore sweeps every do-care combination of one slot against single-digit changes, and drives many headers built from other slots' contents. Faults in the status flags show up in `found_n` and `looking` one cycle after the write or win that should have moved them.

// File: rtl/page_req_pkg.sv
package page_req_pkg;
  localparam int REQ_COLS = 7;
  localparam int ENTRY_W  = 5;
  localparam int DIGIT_W  = 4;
  localparam int COL_W    = 3;
  localparam int CARE_BIT = 4;
  localparam int HOLD_BIT = 3;
  localparam int HOLD_COL = 0;

  typedef logic [ENTRY_W-1:0] req_entry_t;
  typedef logic [DIGIT_W-1:0] digit_t;

  // Width of the meaningful digit bits in each column.
  function automatic digit_t col_mask(input int col);
    case (col)
      0:       col_mask = 4'b0111;
      3:       col_mask = 4'b0011;
      5:       col_mask = 4'b0111;
      default: col_mask = 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/page_req_store.sv
module page_req_store
  import page_req_pkg::*;
#(
  parameter int NSLOT  = 8,
  parameter int SLOT_W = 3
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 we,
  input  logic [SLOT_W-1:0]                    slot,
  input  logic [COL_W-1:0]                     col,
  input  req_entry_t                           data,
  output req_entry_t [NSLOT-1:0][REQ_COLS-1:0] ent_o,
  output logic                                 wr_ok_o
);
  // Column 7 has no storage, so such writes are dropped.
  assign wr_ok_o = we && (int'(col) < REQ_COLS);

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    for (genvar c = 0; c < REQ_COLS; c++) begin : g_col
      always_ff @(posedge clk) begin
        if (rst) begin
          ent_o[s][c] <= '0;
        end else if (wr_ok_o && slot == SLOT_W'(s) && col == COL_W'(c)) begin
          ent_o[s][c] <= data;
        end
      end
    end
  end
endmodule

// File: rtl/page_req_slot_cmp.sv
module page_req_slot_cmp
  import page_req_pkg::*;
(
  input  req_entry_t [REQ_COLS-1:0] ent_i,
  input  digit_t     [REQ_COLS-1:0] hdr_i,
  output logic                      match_o
);
  logic [REQ_COLS-1:0] col_ok;

  for (genvar c = 0; c < REQ_COLS; c++) begin : g_col
    assign col_ok[c] = !ent_i[c][CARE_BIT] ||
                       (((ent_i[c][DIGIT_W-1:0] ^ hdr_i[c]) & col_mask(c)) == '0);
  end

  assign match_o = &col_ok;
endmodule

// File: rtl/page_req_prio.sv
module page_req_prio #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/page_req_matcher.sv
module page_req_matcher
  import page_req_pkg::*;
#(
  parameter  int NUM_GROUPS  = 2,
  parameter  int GROUP_SLOTS = 4,
  localparam int NSLOT  = NUM_GROUPS * GROUP_SLOTS,
  localparam int SLOT_W = $clog2(NSLOT),
  localparam int GRP_W  = $clog2(NUM_GROUPS),
  localparam int IDX_W  = $clog2(GROUP_SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_we,
  input  logic [SLOT_W-1:0] req_slot,
  input  logic [2:0]        req_col,
  input  logic [4:0]        req_data,
  input  logic [GRP_W-1:0]  grp_sel,
  input  logic              hdr_valid,
  input  logic              hdr_ham_err,
  input  logic [2:0]        hdr_mag,
  input  logic [3:0]        hdr_pg_tens,
  input  logic [3:0]        hdr_pg_units,
  input  logic [1:0]        hdr_hr_tens,
  input  logic [3:0]        hdr_hr_units,
  input  logic [2:0]        hdr_mn_tens,
  input  logic [3:0]        hdr_mn_units,
  output logic              res_valid,
  output logic              res_hit,
  output logic [SLOT_W-1:0] res_slot,
  output logic              res_capture,
  output logic              res_held,
  output logic [NSLOT-1:0]  found_n,
  output logic [NSLOT-1:0]  looking
);
  req_entry_t [NSLOT-1:0][REQ_COLS-1:0] ent;
  digit_t     [REQ_COLS-1:0]            hdr_dig;
  logic                                 wr_ok;
  logic [NSLOT-1:0]                     slot_hit;
  logic [GROUP_SLOTS-1:0]               grp_hit;
  logic                                 win_any;
  logic [IDX_W-1:0]                     win_idx;
  logic [SLOT_W-1:0]                    win_slot;
  logic                                 win_hold;

  assign hdr_dig[0] = {1'b0, hdr_mag};
  assign hdr_dig[1] = hdr_pg_tens;
  assign hdr_dig[2] = hdr_pg_units;
  assign hdr_dig[3] = {2'b00, hdr_hr_tens};
  assign hdr_dig[4] = hdr_hr_units;
  assign hdr_dig[5] = {1'b0, hdr_mn_tens};
  assign hdr_dig[6] = hdr_mn_units;

  page_req_store #(
    .NSLOT (NSLOT),
    .SLOT_W(SLOT_W)
  ) store_i (
    .clk    (clk),
    .rst    (rst),
    .we     (req_we),
    .slot   (req_slot),
    .col    (req_col),
    .data   (req_data),
    .ent_o  (ent),
    .wr_ok_o(wr_ok)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_cmp
    page_req_slot_cmp cmp_i (
      .ent_i  (ent[s]),
      .hdr_i  (hdr_dig),
      .match_o(slot_hit[s])
    );
  end

  // Only the selected group competes; a damaged header competes not at all.
  assign grp_hit = slot_hit[int'(grp_sel)*GROUP_SLOTS +: GROUP_SLOTS]
                 & {GROUP_SLOTS{hdr_valid && !hdr_ham_err}};

  page_req_prio #(
    .N    (GROUP_SLOTS),
    .IDX_W(IDX_W)
  ) prio_i (
    .req_i(grp_hit),
    .any_o(win_any),
    .idx_o(win_idx)
  );

  assign win_slot = SLOT_W'(int'(grp_sel) * GROUP_SLOTS + int'(win_idx));
  assign win_hold = ent[win_slot][HOLD_COL][HOLD_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid   <= 1'b0;
      res_hit     <= 1'b0;
      res_slot    <= '0;
      res_capture <= 1'b0;
      res_held    <= 1'b0;
    end else begin
      res_valid   <= hdr_valid;
      res_hit     <= win_any;
      res_slot    <= win_any ? win_slot : '0;
      res_capture <= win_any && win_hold;
      res_held    <= win_any && !win_hold;
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_stat
    always_ff @(posedge clk) begin
      if (rst) begin
        looking[s] <= 1'b0;
        found_n[s] <= 1'b1;
      end else if (wr_ok && req_slot == SLOT_W'(s)) begin
        looking[s] <= 1'b1;
        found_n[s] <= 1'b1;
      end else if (win_any && win_slot == SLOT_W'(s)) begin
        looking[s] <= 1'b0;
        found_n[s] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/page_req_matcher_chk.sv
module page_req_matcher_chk #(
  parameter  int NUM_GROUPS  = 2,
  parameter  int GROUP_SLOTS = 4,
  localparam int NSLOT  = NUM_GROUPS * GROUP_SLOTS,
  localparam int SLOT_W = $clog2(NSLOT),
  localparam int GRP_W  = $clog2(NUM_GROUPS)
) (
  input logic              clk,
  input logic              rst,
  input logic              req_we,
  input logic [SLOT_W-1:0] req_slot,
  input logic [2:0]        req_col,
  input logic [GRP_W-1:0]  grp_sel,
  input logic              hdr_valid,
  input logic              hdr_ham_err,
  input logic              res_valid,
  input logic              res_hit,
  input logic [SLOT_W-1:0] res_slot,
  input logic              res_capture,
  input logic              res_held,
  input logic [NSLOT-1:0]  found_n,
  input logic [NSLOT-1:0]  looking
);
  assert_valid_follows_R6: assert property (@(posedge clk) disable iff (rst)
    hdr_valid |=> res_valid);

  assert_valid_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !hdr_valid |=> !res_valid);

  assert_nohit_zero_R6: assert property (@(posedge clk) disable iff (rst)
    !res_hit |-> (res_slot == '0 && !res_capture && !res_held));

  assert_ham_blocks_R5: assert property (@(posedge clk) disable iff (rst)
    (hdr_valid && hdr_ham_err) |=> !res_hit);

  assert_one_decision_R7: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> (res_capture ^ res_held));

  assert_in_group_R3: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> (int'(res_slot) / GROUP_SLOTS) == int'($past(grp_sel)));

  assert_write_arms_R9: assert property (@(posedge clk) disable iff (rst)
    (req_we && req_col != 3'd7) |=> (looking[$past(req_slot)] && found_n[$past(req_slot)]));

  assert_win_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (res_hit && !$past(req_we)) |-> (!found_n[res_slot] && !looking[res_slot]));
endmodule

bind page_req_matcher page_req_matcher_chk #(
  .NUM_GROUPS (NUM_GROUPS),
  .GROUP_SLOTS(GROUP_SLOTS)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .req_we     (req_we),
  .req_slot   (req_slot),
  .req_col    (req_col),
  .grp_sel    (grp_sel),
  .hdr_valid  (hdr_valid),
  .hdr_ham_err(hdr_ham_err),
  .res_valid  (res_valid),
  .res_hit    (res_hit),
  .res_slot   (res_slot),
  .res_capture(res_capture),
  .res_held   (res_held),
  .found_n    (found_n),
  .looking    (looking)
);

// File: tb/page_req_matcher_tb_top.sv
module page_req_matcher_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;

  logic       clk = 1'b0;
  logic       rst;
  logic       req_we;
  logic [2:0] req_slot;
  logic [2:0] req_col;
  logic [4:0] req_data;
  logic       grp_sel;
  logic       hdr_valid;
  logic       hdr_ham_err;
  logic [2:0] hdr_mag;
  logic [3:0] hdr_pg_tens;
  logic [3:0] hdr_pg_units;
  logic [1:0] hdr_hr_tens;
  logic [3:0] hdr_hr_units;
  logic [2:0] hdr_mn_tens;
  logic [3:0] hdr_mn_units;
  logic       res_valid;
  logic       res_hit;
  logic [2:0] res_slot;
  logic       res_capture;
  logic       res_held;
  logic [7:0] found_n;
  logic [7:0] looking;

  int checks = 0;
  int errors = 0;
  logic [31:0] seed = 32'h1234_5678;

  logic [4:0] m_ent [8][7];
  logic [7:0] m_look;
  logic [7:0] m_fnd;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_req_matcher dut_i (
    .clk(clk), .rst(rst),
    .req_we(req_we), .req_slot(req_slot), .req_col(req_col), .req_data(req_data),
    .grp_sel(grp_sel),
    .hdr_valid(hdr_valid), .hdr_ham_err(hdr_ham_err),
    .hdr_mag(hdr_mag), .hdr_pg_tens(hdr_pg_tens), .hdr_pg_units(hdr_pg_units),
    .hdr_hr_tens(hdr_hr_tens), .hdr_hr_units(hdr_hr_units),
    .hdr_mn_tens(hdr_mn_tens), .hdr_mn_units(hdr_mn_units),
    .res_valid(res_valid), .res_hit(res_hit), .res_slot(res_slot),
    .res_capture(res_capture), .res_held(res_held),
    .found_n(found_n), .looking(looking)
  );

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed ^ (seed >> 15);
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Expected winner from the stored requests (R2..R5); -1 means no match.
  function automatic int exp_win(input logic [6:0][3:0] hv, input logic ham, input int grp);
    if (ham) return -1;
    for (int k = 0; k < 4; k++) begin
      int s;
      bit ok;
      s  = grp * 4 + k;
      ok = 1'b1;
      if (m_ent[s][0][4] && m_ent[s][0][2:0] != hv[0][2:0]) ok = 1'b0;
      if (m_ent[s][1][4] && m_ent[s][1][3:0] != hv[1])      ok = 1'b0;
      if (m_ent[s][2][4] && m_ent[s][2][3:0] != hv[2])      ok = 1'b0;
      if (m_ent[s][3][4] && m_ent[s][3][1:0] != hv[3][1:0]) ok = 1'b0;
      if (m_ent[s][4][4] && m_ent[s][4][3:0] != hv[4])      ok = 1'b0;
      if (m_ent[s][5][4] && m_ent[s][5][2:0] != hv[5][2:0]) ok = 1'b0;
      if (m_ent[s][6][4] && m_ent[s][6][3:0] != hv[6])      ok = 1'b0;
      if (ok) return s;
    end
    return -1;
  endfunction

  // R1 / R10: entry write; column 7 leaves the model untouched.
  task automatic wr(input int s, input int c, input logic [4:0] d);
    @(negedge clk);
    req_we = 1'b1; req_slot = s[2:0]; req_col = c[2:0]; req_data = d;
    @(negedge clk);
    req_we = 1'b0;
    if (c < 7) begin
      m_ent[s][c] = d;
      m_look[s] = 1'b1;
      m_fnd[s]  = 1'b1;
    end
  endtask

  task automatic send_hdr(input logic [6:0][3:0] hv, input logic ham,
                          input bit do_wr, input int ws, input int wc, input string tag);
    int ew;
    logic ecap;
    @(negedge clk);
    hdr_mag = hv[0][2:0]; hdr_pg_tens = hv[1]; hdr_pg_units = hv[2];
    hdr_hr_tens = hv[3][1:0]; hdr_hr_units = hv[4];
    hdr_mn_tens = hv[5][2:0]; hdr_mn_units = hv[6];
    hdr_ham_err = ham; hdr_valid = 1'b1;
    if (do_wr) begin
      req_we = 1'b1; req_slot = ws[2:0]; req_col = wc[2:0]; req_data = m_ent[ws][wc];
    end
    ew = exp_win(hv, ham, int'(grp_sel));
    ecap = (ew >= 0) && m_ent[(ew >= 0) ? ew : 0][0][3];
    @(negedge clk);
    hdr_valid = 1'b0; req_we = 1'b0;
    if (ew >= 0) begin m_look[ew] = 1'b0; m_fnd[ew] = 1'b0; end
    if (do_wr) begin m_look[ws] = 1'b1; m_fnd[ws] = 1'b1; end
    chk({tag, " R6 res_valid"}, 32'(res_valid), 32'd1);
    chk({tag, " R4 res_hit"}, 32'(res_hit), 32'(ew >= 0));
    chk({tag, " R4 res_slot"}, 32'(res_slot), (ew >= 0) ? 32'(ew) : 32'd0);
    chk({tag, " R7 res_capture"}, 32'(res_capture), 32'(ecap));
    chk({tag, " R7 res_held"}, 32'(res_held), 32'((ew >= 0) && !ecap));
    chk({tag, " R9 looking"}, 32'(looking), 32'(m_look));
    chk({tag, " R8 found_n"}, 32'(found_n), 32'(m_fnd));
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [6:0][3:0] base;
    logic [6:0][3:0] hv;
    for (int s = 0; s < 8; s++)
      for (int c = 0; c < 7; c++) m_ent[s][c] = '0;
    m_look = '0; m_fnd = '1;
    rst = 1'b1; req_we = 1'b0; req_slot = '0; req_col = '0; req_data = '0;
    grp_sel = 1'b0; hdr_valid = 1'b0; hdr_ham_err = 1'b0;
    hdr_mag = '0; hdr_pg_tens = '0; hdr_pg_units = '0; hdr_hr_tens = '0;
    hdr_hr_units = '0; hdr_mn_tens = '0; hdr_mn_units = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    chk("R11 res_valid", 32'(res_valid), 32'd0);
    chk("R11 res_hit", 32'(res_hit), 32'd0);
    chk("R11 looking", 32'(looking), 32'd0);
    chk("R11 found_n", 32'(found_n), 32'hFF);

    // R11: cleared entries match anything and are held
    base[0] = 4'd5; base[1] = 4'd3; base[2] = 4'd7; base[3] = 4'd2;
    base[4] = 4'd9; base[5] = 4'd4; base[6] = 4'd1;
    send_hdr(base, 1'b0, 1'b0, 0, 0, "R11 grp0");
    grp_sel = 1'b1;
    send_hdr(base, 1'b0, 1'b0, 0, 0, "R11 grp1 R3");
    grp_sel = 1'b0;

    // R2 exhaustive do-care sweep on slot 0; slots 1..3 require magazine 7
    for (int s = 1; s < 4; s++) wr(s, 0, 5'b10111);
    for (int m = 0; m < 128; m++) begin
      logic [6:0] mk;
      mk = m[6:0];
      wr(0, 0, {mk[0], mk[1] ^ mk[5], base[0][2:0]});
      for (int c = 1; c < 7; c++) wr(0, c, {mk[c], base[c]});
      send_hdr(base, 1'b0, 1'b0, 0, 0, "R2 exact");
      for (int f = 0; f < 7; f++) begin
        hv = base;
        hv[f] = base[f] ^ 4'b0001;
        send_hdr(hv, 1'b0, 1'b0, 0, 0, "R2 one digit off");
      end
    end

    // R5: matching header with an error flag
    send_hdr(base, 1'b1, 1'b0, 0, 0, "R5 ham");

    // R10: column 7 write leaves status untouched
    wr(2, 7, 5'h1F);
    chk("R10 looking", 32'(looking), 32'(m_look));
    chk("R10 found_n", 32'(found_n), 32'(m_fnd));

    // R9: write and win on the same slot in the same cycle
    wr(0, 0, {1'b1, 1'b1, base[0][2:0]});
    send_hdr(base, 1'b0, 1'b1, 0, 2, "R9 same cycle");

    // R1 R3 R4 random programming and headers
    for (int s = 0; s < 8; s++)
      for (int c = 0; c < 7; c++) begin
        logic [31:0] r;
        r = rnd();
        wr(s, c, {r[9] & r[10], r[3:0]});
      end
    for (int it = 0; it < 2500; it++) begin
      logic [31:0] r;
      logic [31:0] q;
      int s;
      r = rnd();
      if (r[1:0] == 2'd0) begin
        q = rnd();
        wr(int'(q[2:0]), int'(q[5:3]), q[10:6]);
      end
      grp_sel = r[4];
      s = int'(r[4]) * 4 + int'(r[6:5]);
      for (int c = 0; c < 7; c++) hv[c] = m_ent[s][c][3:0];
      if (r[7]) begin
        q = rnd();
        hv[int'(q[2:0]) % 7] = q[7:4];
      end
      q = rnd();
      send_hdr(hv, (r[10:8] == 3'd0), (r[14:11] == 4'd0),
               int'(q[2:0]), int'(q[5:3]) % 7, "R1 R3 sweep");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule